// File: doc/BRIEF.md
# Pattern-Table Bank Translator with Selectable Window Size

This block turns a pattern-table fetch address from the picture processor into an address in character ROM. The picture processor's pattern space covers 0x0000 to 0x1FFF. The block cuts that space into banked windows and gives each window a bank number held in one of eight 8-bit bank registers. The host CPU loads those registers through a plain one-cycle write strobe.

The window size is not set by a single mode bit. It comes from the history of CPU writes. A write to the mode-request address (0x8000) arms the large-window layout: four 2 KiB windows. Any write to bank registers 2 through 5 vetoes that layout for good, because those registers exist only in the small-window layout of eight 1 KiB windows. Both marks are sticky until reset.

The translation is purely combinational. A change on the picture-processor address shows on the ROM address in the same cycle. A CPU write is visible from the clock edge that captures it. There is no stream interface and so no back-pressure: the picture processor presents an address and the block answers at once. Addresses at 0x2000 and above do not belong to pattern space. For those the block raises a not-selected flag.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset all eight bank registers hold 0 and both sticky marks are clear, so the block is in the 1 KiB layout.
- R2: A strobed write to CPU address 0x8310+n (n = 0..7) loads bank register n with the write data. Writes to any other address leave every bank register unchanged.
- R3: A strobed write to CPU address 0x8000 sets the large-window request mark. The mark stays set until reset.
- R4: A strobed write to CPU address 0x8312, 0x8313, 0x8314 or 0x8315 sets the veto mark. The mark stays set until reset. Writes to registers 0, 1, 6 and 7 never set it.
- R5: The 2 KiB layout is in force only while the request mark is set and the veto mark is clear. In every other state the 1 KiB layout applies, whatever order the writes came in.
- R6: In the 2 KiB layout, window w = ppu_addr[12:11] takes its bank from register 0, 1, 6 or 7 for w = 0, 1, 2, 3 respectively. chr_addr = bank*2048 + ppu_addr[10:0].
- R7: In the 1 KiB layout, window n = ppu_addr[12:10] takes register n. The effective 10-bit bank has bits 7:0 equal to the register and bits 9:8 equal to register bits 5:4. chr_addr = bank*1024 + ppu_addr[9:0].
- R8: When ppu_addr[13] is 1, chr_nsel is 1 and chr_addr is 0. Otherwise chr_nsel is 0.
- R9: While cpu_wr_en is 0, the CPU address and data have no effect on the bank registers or on the marks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for register and mark updates |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture-processor fetch address |
| chr_addr | output | 20 | Character ROM byte address |
| chr_nsel | output | 1 | High when ppu_addr lies outside pattern space |

## Verification
The bench sweeps every picture-processor address after each change of register contents or marks, and compares each one against an arithmetic model. The corner cases are:

- **2 KiB register order.** The bench fills registers 0, 1, 6 and 7 with distinct values. A translator that used registers 2 and 3 for the upper windows would return the wrong bank there.
- **Bit replication in the 1 KiB layout.** The bench uses values with bits 5:4 set. A translator that dropped the replication would lose address bits 19:18.
- **Write history.** The bench writes to the request address after a veto write, and writes to a veto register after a request. A design with a non-sticky veto, or one that decided the layout by the latest write, would flip back to 2 KiB.
- **Near-miss addresses.** The bench writes to 0x8318, 0x830F, 0x0310 and 0xC310, and drives a write pattern with the strobe low. An incomplete address decode, or one that ignored the strobe, would corrupt a register.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  localparam int CPU_AW        = 16;
  localparam int CPU_DW        = 8;
  localparam int PPU_AW        = 14;
  localparam int NUM_BANK_REGS = 8;
  localparam int SMALL_WIN_W   = 10;
  localparam int LARGE_WIN_W   = 11;
  localparam int REPL_BITS     = 2;
  localparam int REPL_LSB      = 4;
  localparam int SMALL_BANK_W  = CPU_DW + REPL_BITS;
  localparam int CHR_AW        = SMALL_BANK_W + SMALL_WIN_W;

  localparam logic [CPU_AW-1:0] BANK_REG_BASE = 16'h8310;
  localparam logic [CPU_AW-1:0] LARGE_REQ_ADDR = 16'h8000;

  localparam int VETO_IDX_LO = 2;
  localparam int VETO_IDX_HI = 5;

  typedef enum logic {
    GRAN_1K = 1'b0,
    GRAN_2K = 1'b1
  } gran_e;

endpackage

// File: rtl/chr_reg_file.sv
module chr_reg_file #(
  parameter int                  AW    = 16,
  parameter int                  DW    = 8,
  parameter int                  NREG  = 8,
  parameter logic [AW-1:0]       BASE  = 16'h8310
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic                 wr_hit,
  output logic [$clog2(NREG)-1:0] wr_idx,
  output logic [NREG*DW-1:0]   regs_flat
);

  localparam int IDX_W = $clog2(NREG);

  // A register write hits when the upper address bits match the base page.
  assign wr_hit = wr_en && (wr_addr[AW-1:IDX_W] == BASE[AW-1:IDX_W]);
  assign wr_idx = wr_addr[IDX_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    logic [DW-1:0] bank_q;
    logic          load;

    assign load = wr_hit && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= '0;
      end else if (load) begin
        bank_q <= wr_data;
      end
    end

    assign regs_flat[g*DW +: DW] = bank_q;
  end

endmodule

// File: rtl/chr_mode_ctl.sv
module chr_mode_ctl
  import chr_map_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              IDX_W    = 3,
  parameter logic [AW-1:0]   REQ_ADDR = 16'h8000,
  parameter int              VETO_LO  = 2,
  parameter int              VETO_HI  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             reg_hit,
  input  logic [IDX_W-1:0] reg_idx,
  output logic             req_q,
  output logic             veto_q,
  output gran_e            gran
);

  logic req_set;
  logic veto_set;

  assign req_set  = wr_en && (wr_addr == REQ_ADDR);
  assign veto_set = reg_hit &&
                    (reg_idx >= IDX_W'(VETO_LO)) &&
                    (reg_idx <= IDX_W'(VETO_HI));

  // Both marks only ever set; reset is the sole way back.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      veto_q <= 1'b0;
    end else begin
      if (req_set)  req_q  <= 1'b1;
      if (veto_set) veto_q <= 1'b1;
    end
  end

  always_comb begin
    gran = GRAN_1K;
    if (req_q && !veto_q) gran = GRAN_2K;
  end

endmodule

// File: rtl/chr_addr_xlate.sv
module chr_addr_xlate
  import chr_map_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NREG   = 8,
  parameter int PPU_W  = 14,
  parameter int SWIN_W = 10,
  parameter int LWIN_W = 11,
  parameter int RBITS  = 2,
  parameter int RLSB   = 4,
  parameter int OUT_W  = 20
) (
  input  logic [NREG*DW-1:0] regs_flat,
  input  gran_e              gran,
  input  logic [PPU_W-1:0]   ppu_addr,
  output logic [OUT_W-1:0]   chr_addr,
  output logic               chr_nsel
);

  localparam int IDX_W   = $clog2(NREG);
  localparam int SBANK_W = DW + RBITS;
  localparam int LWIN_N  = 2;

  logic [DW-1:0] bank_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign bank_arr[g] = regs_flat[g*DW +: DW];
  end

  // Small-window path: index is the three bits above the window offset.
  logic [IDX_W-1:0]   s_idx;
  logic [DW-1:0]      s_raw;
  logic [SBANK_W-1:0] s_bank;
  logic [OUT_W-1:0]   s_addr;

  assign s_idx  = ppu_addr[SWIN_W +: IDX_W];
  assign s_raw  = bank_arr[s_idx];
  assign s_bank = {s_raw[RLSB +: RBITS], s_raw};
  assign s_addr = OUT_W'({s_bank, ppu_addr[SWIN_W-1:0]});

  // Large-window path: windows 0..3 use registers 0,1,6,7, i.e. the window
  // number's high bit is copied into the two upper index bits.
  logic [LWIN_N-1:0]  l_win;
  logic [IDX_W-1:0]   l_idx;
  logic [DW-1:0]      l_raw;
  logic [OUT_W-1:0]   l_addr;

  assign l_win  = ppu_addr[LWIN_W +: LWIN_N];
  assign l_idx  = {l_win[1], l_win[1], l_win[0]};
  assign l_raw  = bank_arr[l_idx];
  assign l_addr = OUT_W'({l_raw, ppu_addr[LWIN_W-1:0]});

  always_comb begin
    chr_nsel = ppu_addr[PPU_W-1];
    chr_addr = '0;
    if (!chr_nsel) begin
      chr_addr = (gran == GRAN_2K) ? l_addr : s_addr;
    end
  end

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int CPU_AW_P = CPU_AW,
  parameter int CPU_DW_P = CPU_DW,
  parameter int PPU_AW_P = PPU_AW,
  parameter int NREG_P   = NUM_BANK_REGS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr_en,
  input  logic [CPU_AW_P-1:0] cpu_addr,
  input  logic [CPU_DW_P-1:0] cpu_wdata,
  input  logic [PPU_AW_P-1:0] ppu_addr,
  output logic [CPU_DW_P+REPL_BITS+SMALL_WIN_W-1:0] chr_addr,
  output logic                chr_nsel
);

  localparam int IDX_W  = $clog2(NREG_P);
  localparam int OUT_W  = CPU_DW_P + REPL_BITS + SMALL_WIN_W;

  logic                       reg_hit;
  logic [IDX_W-1:0]           reg_idx;
  logic [NREG_P*CPU_DW_P-1:0] regs_flat;
  logic                       req_q;
  logic                       veto_q;
  gran_e                      gran;

  chr_reg_file #(
    .AW   (CPU_AW_P),
    .DW   (CPU_DW_P),
    .NREG (NREG_P),
    .BASE (CPU_AW_P'(BANK_REG_BASE))
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cpu_wr_en),
    .wr_addr   (cpu_addr),
    .wr_data   (cpu_wdata),
    .wr_hit    (reg_hit),
    .wr_idx    (reg_idx),
    .regs_flat (regs_flat)
  );

  chr_mode_ctl #(
    .AW       (CPU_AW_P),
    .IDX_W    (IDX_W),
    .REQ_ADDR (CPU_AW_P'(LARGE_REQ_ADDR)),
    .VETO_LO  (VETO_IDX_LO),
    .VETO_HI  (VETO_IDX_HI)
  ) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr_en),
    .wr_addr (cpu_addr),
    .reg_hit (reg_hit),
    .reg_idx (reg_idx),
    .req_q   (req_q),
    .veto_q  (veto_q),
    .gran    (gran)
  );

  chr_addr_xlate #(
    .DW     (CPU_DW_P),
    .NREG   (NREG_P),
    .PPU_W  (PPU_AW_P),
    .SWIN_W (SMALL_WIN_W),
    .LWIN_W (LARGE_WIN_W),
    .RBITS  (REPL_BITS),
    .RLSB   (REPL_LSB),
    .OUT_W  (OUT_W)
  ) u_xlate (
    .regs_flat (regs_flat),
    .gran      (gran),
    .ppu_addr  (ppu_addr),
    .chr_addr  (chr_addr),
    .chr_nsel  (chr_nsel)
  );

endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk
  import chr_map_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cpu_wr_en,
  input logic [CPU_AW-1:0]             cpu_addr,
  input logic [CPU_DW-1:0]             cpu_wdata,
  input logic [PPU_AW-1:0]             ppu_addr,
  input logic [CHR_AW-1:0]             chr_addr,
  input logic                          chr_nsel,
  input logic [NUM_BANK_REGS*CPU_DW-1:0] regs_flat,
  input logic                          req_q,
  input logic                          veto_q,
  input gran_e                         gran
);

  localparam int IDX_W = $clog2(NUM_BANK_REGS);

  logic              hit_d;
  logic [IDX_W-1:0]  idx_d;
  logic [CPU_DW-1:0] data_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_d  <= 1'b0;
      idx_d  <= '0;
      data_d <= '0;
    end else begin
      hit_d  <= cpu_wr_en && (cpu_addr[CPU_AW-1:IDX_W] == BANK_REG_BASE[CPU_AW-1:IDX_W]);
      idx_d  <= cpu_addr[IDX_W-1:0];
      data_d <= cpu_wdata;
    end
  end

  // R2: a hitting write is visible in its register one edge later
  a_r2_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
    hit_d |-> (regs_flat[idx_d*CPU_DW +: CPU_DW] == data_d));

  // R3: the request mark never clears without reset
  a_r3_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q);

  // R4: the veto mark never clears without reset
  a_r4_veto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    veto_q |=> veto_q);

  // R5: a veto always keeps the small layout
  a_r5_veto_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    veto_q |-> (gran == GRAN_1K));

  // R6: large layout keeps the 11 offset bits and leaves the top bit clear
  a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (!chr_nsel && gran == GRAN_2K) |->
      (chr_addr[10:0] == ppu_addr[10:0] && !chr_addr[CHR_AW-1]));

  // R7: small layout keeps the 10 offset bits
  a_r7_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (!chr_nsel && gran == GRAN_1K) |-> (chr_addr[9:0] == ppu_addr[9:0]));

  // R8: outside pattern space the address is forced to zero
  a_r8_nsel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    chr_nsel |-> (chr_addr == '0));

  // R8: the not-selected flag follows the top fetch-address bit
  a_r8_nsel_range: assert property (@(posedge clk) disable iff (!rst_n)
    chr_nsel == ppu_addr[PPU_AW-1]);

  // R9: without a strobe the bank registers hold
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr_en |=> $stable(regs_flat));

endmodule

bind chr_bank_mapper chr_bank_mapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_wr_en (cpu_wr_en),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .ppu_addr  (ppu_addr),
  .chr_addr  (chr_addr),
  .chr_nsel  (chr_nsel),
  .regs_flat (regs_flat),
  .req_q     (req_q),
  .veto_q    (veto_q),
  .gran      (gran)
);

// File: tb/chr_bank_mapper_bench.sv
module chr_bank_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] ppu_addr = '0;
  logic [19:0] chr_addr;
  logic        chr_nsel;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int  mreg [8];
  bit  mreq;
  bit  mveto;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_bank_mapper u_chr_bank_mapper (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr_en (cpu_wr_en),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .ppu_addr  (ppu_addr),
    .chr_addr  (chr_addr),
    .chr_nsel  (chr_nsel)
  );

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    mreq  = 1'b0;
    mveto = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cpu_write(input int addr, input int data);
    @(negedge clk);
    cpu_addr  = 16'(addr);
    cpu_wdata = 8'(data);
    cpu_wr_en = 1'b1;
    @(negedge clk);
    cpu_wr_en = 1'b0;
    if (addr >= 'h8310 && addr <= 'h8317) begin
      mreg[addr - 'h8310] = data;
      if ((addr - 'h8310) >= 2 && (addr - 'h8310) <= 5) mveto = 1'b1;
    end
    if (addr == 'h8000) mreq = 1'b1;
  endtask

  // Strobe held low while a matching address and data are presented
  task automatic idle_pattern(input int addr, input int data);
    @(negedge clk);
    cpu_addr  = 16'(addr);
    cpu_wdata = 8'(data);
    cpu_wr_en = 1'b0;
    @(negedge clk);
  endtask

  function automatic int expect_addr(input int pa);
    int w, b;
    if (pa >= 'h2000) return 0;
    if (mreq && !mveto) begin
      w = (pa >> 11) & 3;
      case (w)
        0: b = mreg[0];
        1: b = mreg[1];
        2: b = mreg[6];
        default: b = mreg[7];
      endcase
      return b * 2048 + (pa % 2048);
    end
    b = mreg[(pa >> 10) & 7];
    b = b + ((b >> 4) & 3) * 256;
    return b * 1024 + (pa % 1024);
  endfunction

  task automatic sweep(input string tag);
    int ea;
    bit en;
    for (int pa = 0; pa < 'h4000; pa++) begin
      ppu_addr = 14'(pa);
      #1;
      ea = expect_addr(pa);
      en = (pa >= 'h2000);
      vectors++;
      if (chr_addr !== 20'(ea) || chr_nsel !== en) begin
        miscompares++;
        if (miscompares <= 20)
          $display("FAIL %s ppu_addr=%h actual addr=%h nsel=%b expected addr=%h nsel=%b",
                   tag, pa, chr_addr, chr_nsel, ea, en);
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    sweep("R1 R7 R8 reset state");

    // R2 R7: registers with bits 5:4 set to exercise replication
    cpu_write('h8310, 'h3F);
    cpu_write('h8311, 'h10);
    cpu_write('h8316, 'hA5);
    cpu_write('h8317, 'hFF);
    sweep("R2 R7 partial load");

    // R2 R9: near-miss addresses and unstrobed patterns
    cpu_write('h8318, 'h77);
    cpu_write('h830F, 'h66);
    cpu_write('h0310, 'h55);
    cpu_write('hC310, 'h44);
    idle_pattern('h8310, 'h99);
    idle_pattern('h8313, 'h99);
    idle_pattern('h8000, 'h00);
    sweep("R2 R9 ignored writes");

    // R3 R5 R6: request mark -> large layout
    cpu_write('h8000, 'h00);
    sweep("R3 R5 R6 large layout");

    // R4: writes to 0,1,6,7 do not veto
    cpu_write('h8310, 'h2C);
    cpu_write('h8311, 'hD3);
    cpu_write('h8316, 'h81);
    cpu_write('h8317, 'h7E);
    sweep("R4 R6 no veto");

    // R4 R5: veto via register 3
    cpu_write('h8313, 'h31);
    sweep("R4 R5 veto");
    cpu_write('h8000, 'h12);
    cpu_write('h8312, 'hE7);
    cpu_write('h8314, 'h20);
    cpu_write('h8315, 'h0B);
    sweep("R3 R4 R7 sticky veto");

    // R1 R5: reset clears marks; veto before request stays small layout
    do_reset();
    sweep("R1 after second reset");
    cpu_write('h8314, 'h35);
    cpu_write('h8310, 'h12);
    cpu_write('h8000, 'h00);
    sweep("R5 veto then request");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule